// File: doc/BRIEF.md
# Byte-Lane EDO DRAM Emulator

This block behaves like the device side of an extended-data-out DRAM with a 16-bit data bus split into two byte lanes. It samples the active-low row strobe, the two lane column strobes, the write strobe, the output-enable strobe and the multiplexed address on a fast system clock. From the sampled levels it decodes the memory function. The possible functions are standby, row-address-only refresh, byte or word reads, early or late byte or word writes, refresh with CAS asserted before RAS using an internal row counter, and hidden refresh. The storage is a small array whose row and column widths are parameters. The full address width is mapped onto that array by taking the low bits of each address phase.

Every strobe and the address and data inputs pass through one register stage. Strobe edges are found by comparing that stage with the previous sample. The decoded action is registered on the following clock. A lane output therefore reacts to a strobe change within three clock edges. Each lane has its own data output and its own drive enable. An external pad ring or bench combines these into a tri-state bus. A sticky flag records protocol violations.

Top module: `edo_dram_emu`

## Requirements
- R1: When the sampled row strobe is high and a lane's column strobe is high, that lane's drive enable is low, whatever the write and output-enable levels.
- R2: A row-strobe fall while both column strobes are high opens the row given by the address. If no column strobe follows, no lane drives and stored data is unchanged.
- R3: A lane's column-strobe fall with a row open, write high and output-enable low loads the stored byte at row/column into that lane and drives it. Lane 0 is dq[7:0] with the lower strobe, and lane 1 is dq[15:8] with the upper strobe. A lane whose strobe stayed high is not newly driven.
- R4: While a lane's column strobe is low, write is low and a row is open, the lane's input byte is stored at the open row and latched column. A lane whose column strobe is high keeps its stored byte.
- R5: If write is low when a lane's column strobe falls, that lane does not drive for the rest of that column access, even if write later rises with output-enable low.
- R6: A row-strobe fall while either column strobe is low opens no row and ignores the address. It advances refresh_row_o by one, wrapping modulo 2^ROW_W.
- R7: Holding a lane's column strobe low while the row strobe goes high and falls again after a read performs a refresh step (R6). That lane keeps driving the read data throughout.
- R8: After a read, the lane data stays driven when its column strobe rises, as long as the row strobe is low. It changes only at the next column-strobe fall. Output-enable high or write low gate it off, and the row strobe going high with the column strobe high ends it.
- R9: A late write starts with write high at the column-strobe fall and then lowers write. It stores the input byte, and the lane does not drive while write is low.
- R10: A column-strobe fall while the row strobe is low and no row is open sets err_o. err_o stays set until reset.
- R11: The row is the low ROW_W address bits at the row-strobe fall. The column is the low COL_W address bits at the column-strobe fall. Higher address bits alias.
- R12: After reset, no lane drives, refresh_row_o is 0 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| lcas_ni | input | 1 | Lower-lane column strobe, active low |
| ucas_ni | input | 1 | Upper-lane column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data toward the bus |
| dq_oe_o | output | 2 | Per-lane drive enable (bit 0 lower, bit 1 upper) |
| refresh_row_o | output | ROW_W | Internal refresh row counter |
| err_o | output | 1 | Sticky protocol violation flag |

## Verification
The bench first raises write after an early write while output-enable is low. A design that recorded only the current write level would turn the outputs on with stale data. It then raises the column strobe after a read with the row still open. A plain page-mode design would drop the bus there instead of holding it. In a hidden refresh the row strobe toggles under a held column strobe. A design that tied the outputs to the row strobe alone would go high impedance, and one that re-latched a row would not advance the counter. Byte writes to one lane, address aliasing, counter wrap after sixteen refreshes, and a column access after a refresh with no row open complete the set.

// File: rtl/edo_pkg.sv
package edo_pkg;
  // sampled strobe levels, all active low as on the pins
  typedef struct packed {
    logic       ras;
    logic [1:0] cas;
    logic       we;
    logic       oe;
  } strobe_t;

  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/edo_sync.sv
module edo_sync
  import edo_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              lcas_ni,
  input  logic              ucas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output strobe_t           lvl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] din_o,
  output logic              ras_fall_o,
  output logic [LANES-1:0]  cas_fall_o
);
  strobe_t cur_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '1;
      prv_q  <= '1;
      addr_o <= '0;
      din_o  <= '0;
    end else begin
      cur_q  <= '{ras: ras_ni, cas: {ucas_ni, lcas_ni}, we: we_ni, oe: oe_ni};
      prv_q  <= cur_q;
      addr_o <= addr_i;
      din_o  <= dq_i;
    end
  end

  assign lvl_o      = cur_q;
  assign ras_fall_o = prv_q.ras & ~cur_q.ras;
  assign cas_fall_o = prv_q.cas & ~cur_q.cas;

  AST_FALL_ONLY_FROM_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_fall_o |-> $past(ras_ni) == 1'b0);  // R2
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ras_fall_i,
  input  logic [LANES-1:0]  cas_fall_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              row_open_o,
  output logic [ROW_W-1:0]  ref_row_o,
  output logic              err_o
);
  logic [ROW_W-1:0] row_q, ref_q;
  logic [COL_W-1:0] col_q;
  logic             open_q, err_q;
  logic             ras_only, cbr, any_cas_fall, bad_access;

  assign ras_only     = ras_fall_i & (&lvl_i.cas);
  assign cbr          = ras_fall_i & ~(&lvl_i.cas);
  assign any_cas_fall = |cas_fall_i;
  assign bad_access   = any_cas_fall & ~lvl_i.ras & ~open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      ref_q  <= '0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ras_only) begin
        row_q  <= addr_i[ROW_W-1:0];
        open_q <= 1'b1;
      end else if (lvl_i.ras) begin
        open_q <= 1'b0;
      end
      if (cbr) ref_q <= ref_q + 1'b1;
      if (any_cas_fall) col_q <= addr_i[COL_W-1:0];
      if (bad_access) err_q <= 1'b1;
    end
  end

  // lanes capture read data in the fall cycle, before col_q updates
  assign col_o      = any_cas_fall ? addr_i[COL_W-1:0] : col_q;
  assign row_o      = row_q;
  assign row_open_o = open_q;
  assign ref_row_o  = ref_q;
  assign err_o      = err_q;

  AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall_i && lvl_i.cas != 2'b11) |=> ref_row_o == $past(ref_row_o) + 1'b1);  // R6
  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_fall_i && lvl_i.cas != 2'b11) |=> $stable(ref_row_o));  // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);  // R10
  AST_ROW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_open_o && !ras_fall_i) |=> $stable(row_o));  // R11
endmodule

// File: rtl/edo_lane.sv
module edo_lane
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 4,
  parameter int unsigned LANE  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           lvl_i,
  input  logic              cas_fall_i,
  input  logic              row_open_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [LANE_W-1:0] din_i,
  output logic [LANE_W-1:0] dout_o,
  output logic              drive_o
);
  localparam int unsigned IDX_W = ROW_W + COL_W;
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              cas_lo, wr, rd, valid_q;
  logic [LANE_W-1:0] out_q;

  assign idx    = {row_i, col_i};
  assign cas_lo = ~lvl_i.cas[LANE];
  assign wr     = cas_lo & ~lvl_i.we & row_open_i & ~cas_fall_i;
  assign rd     = cas_fall_i & row_open_i & lvl_i.we;

  always_ff @(posedge clk_i) begin
    if (wr) mem[idx] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (rd) begin
      out_q   <= mem[idx];
      valid_q <= 1'b1;
    end else if (cas_fall_i || wr || (lvl_i.ras && !cas_lo)) begin
      // early write, access without row, write, or precharge ends the data
      valid_q <= 1'b0;
    end
  end

  assign dout_o  = out_q;
  assign drive_o = valid_q & ~lvl_i.oe & lvl_i.we & ~(lvl_i.ras & ~cas_lo);

  AST_EARLY_WRITE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_fall_i && !lvl_i.we) |=> !drive_o);  // R5
  AST_LATE_WRITE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> !drive_o);  // R9
  AST_EDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_fall_i |=> $stable(dout_o));  // R8
endmodule

// File: rtl/edo_dram_emu.sv
module edo_dram_emu
  import edo_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              lcas_ni,
  input  logic              ucas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       dq_i,
  output logic [15:0]       dq_o,
  output logic [1:0]        dq_oe_o,
  output logic [ROW_W-1:0]  refresh_row_o,
  output logic              err_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  strobe_t           lvl;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              ras_fall, row_open;
  logic [LANES-1:0]  cas_fall;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;

  edo_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk_i, .rst_ni, .ras_ni, .lcas_ni, .ucas_ni, .we_ni, .oe_ni, .addr_i, .dq_i,
    .lvl_o(lvl), .addr_o(addr_s), .din_o(din_s),
    .ras_fall_o(ras_fall), .cas_fall_o(cas_fall)
  );

  edo_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni, .lvl_i(lvl), .addr_i(addr_s),
    .ras_fall_i(ras_fall), .cas_fall_i(cas_fall),
    .row_o(row), .col_o(col), .row_open_o(row_open),
    .ref_row_o(refresh_row_o), .err_o
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edo_lane #(.ROW_W(ROW_W), .COL_W(COL_W), .LANE(g)) u_lane (
      .clk_i, .rst_ni, .lvl_i(lvl),
      .cas_fall_i(cas_fall[g]), .row_open_i(row_open),
      .row_i(row), .col_i(col),
      .din_i(din_s[g*LANE_W +: LANE_W]),
      .dout_o(dq_o[g*LANE_W +: LANE_W]),
      .drive_o(dq_oe_o[g])
    );
  end
endmodule

// File: tb/sim_edo_dram_emu.sv
module sim_edo_dram_emu;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ras_n = 1, lcas_n = 1, ucas_n = 1, we_n = 1, oe_n = 1;
  logic [8:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe;
  logic [3:0] ref_row;
  logic       err;
  int vectors = 0, fails = 0, cyc = 0;
  logic [3:0] exp_ref = '0;

  always #(CLK_P/2) clk = ~clk;

  edo_dram_emu u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .lcas_ni(lcas_n), .ucas_ni(ucas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(dq_oe), .refresh_row_o(ref_row), .err_o(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_row(input logic [8:0] a);
    addr = a; ras_n = 0; tick(3);
  endtask

  task automatic close_row();
    lcas_n = 1; ucas_n = 1; tick(1);
    ras_n = 1; we_n = 1; oe_n = 1; tick(3);
  endtask

  task automatic cas_go(input logic [1:0] m, input logic [8:0] c, input logic w,
                        input logic o, input logic [15:0] d);
    addr = c; we_n = w; oe_n = o; dq_in = d;
    lcas_n = ~m[0]; ucas_n = ~m[1]; tick(3);
  endtask

  task automatic t_reset();
    chk("R12 oe", dq_oe, 0); chk("R12 ref", ref_row, 0); chk("R12 err", err, 0);
  endtask

  task automatic t_early_word();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 0, 0, 16'hA55A);
    chk("R5 oe during early write", dq_oe, 0);
    we_n = 1; tick(3);
    chk("R5 oe after we rises", dq_oe, 0);
    close_row();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 1, 0, 0);
    chk("R3 word oe", dq_oe, 2'b11); chk("R4 word data", dq_out, 16'hA55A);
    close_row();
  endtask

  task automatic t_byte();
    open_row(9'd3);
    cas_go(2'b10, 9'd5, 0, 1, 16'h12FF);
    close_row();
    open_row(9'd3);
    cas_go(2'b01, 9'd5, 1, 0, 0);
    chk("R3 lower only oe", dq_oe, 2'b01); chk("R4 lower kept", dq_out[7:0], 8'h5A);
    lcas_n = 1; tick(2);
    cas_go(2'b10, 9'd5, 1, 0, 0);
    chk("R4 upper written", dq_out[15:8], 8'h12);
    close_row();
  endtask

  task automatic t_late();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 1, 0, 0);
    chk("R9 read before late write", dq_out, 16'h125A);
    oe_n = 1; we_n = 0; dq_in = 16'hBEEF; tick(3);
    chk("R9 oe while we low", dq_oe, 0);
    we_n = 1; close_row();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 1, 0, 0);
    chk("R9 late write stored", dq_out, 16'hBEEF);
    close_row();
  endtask

  task automatic t_edo();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 1, 0, 0);
    lcas_n = 1; ucas_n = 1; tick(3);
    chk("R8 oe after cas high", dq_oe, 2'b11); chk("R8 data held", dq_out, 16'hBEEF);
    oe_n = 1; tick(3); chk("R8 oe gated", dq_oe, 0);
    oe_n = 0; tick(3); chk("R8 oe back", dq_oe, 2'b11);
    ras_n = 1; tick(3); chk("R1 off at precharge", dq_oe, 0);
    lcas_n = 0; tick(3);
    chk("R1 cas without row", dq_oe, 0); chk("R10 no err with ras high", err, 0);
    lcas_n = 1; oe_n = 1; tick(3);
  endtask

  task automatic t_ras_only();
    open_row(9'd7);
    oe_n = 0; tick(2);
    chk("R2 no drive", dq_oe, 0);
    close_row();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 1, 0, 0);
    chk("R2 data unchanged", dq_out, 16'hBEEF);
    close_row();
  endtask

  task automatic t_cbr();
    lcas_n = 0; tick(2);
    for (int i = 0; i < 16; i++) begin
      addr = 9'h1AB ^ 9'(i); ras_n = 0; tick(3);
      exp_ref = exp_ref + 1'b1;
      if (i < 2) chk("R6 counter step", ref_row, exp_ref);
      ras_n = 1; tick(2);
    end
    chk("R6 counter wrap", ref_row, exp_ref);
    chk("R6 no err", err, 0);
    lcas_n = 1; tick(3);
  endtask

  task automatic t_hidden();
    open_row(9'd3);
    cas_go(2'b11, 9'd5, 1, 0, 0);
    ras_n = 1; tick(3);
    chk("R7 oe during precharge", dq_oe, 2'b11);
    ras_n = 0; tick(3);
    exp_ref = exp_ref + 1'b1;
    chk("R7 oe after refresh", dq_oe, 2'b11); chk("R7 data", dq_out, 16'hBEEF);
    chk("R7 counter", ref_row, exp_ref);
    close_row();
    chk("R1 off after hidden", dq_oe, 0);
  endtask

  task automatic t_alias();
    open_row(9'h1F3);
    cas_go(2'b11, 9'h0F5, 1, 0, 0);
    chk("R11 alias read", dq_out, 16'hBEEF);
    close_row();
  endtask

  task automatic t_err();
    chk("R10 clear before", err, 0);
    lcas_n = 0; tick(2); ras_n = 0; tick(3);
    lcas_n = 1; tick(2); lcas_n = 0; tick(3);
    chk("R10 err set", err, 1);
    ras_n = 1; lcas_n = 1; tick(3);
    chk("R10 err sticky", err, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    tick(3); t_reset();
    rst_n = 1; tick(2); t_reset();
    t_early_word();
    t_byte();
    t_late();
    t_edo();
    t_ras_only();
    t_cbr();
    t_hidden();
    t_alias();
    t_err();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule